// File: doc/BRIEF.md
# Byte-Oriented File-Register ALU Unit

This unit executes two byte-wide instructions against a banked data register file and a working register W. One subtracts W and a pending borrow from a file register. The other exchanges the two nibbles of a file register. A 16-bit instruction word is decoded, and the operand address is formed from either a fixed access window or a bank-select value. The operand is then fetched and processed. The result goes either to W or back to the same file location.

Every instruction runs through the same fixed sequence of phases. The controller states are IDLE, DECODE, READ, PROCESS and WRITE. The transitions are:

- IDLE to DECODE when an instruction is accepted (`instr_valid` while `ready`); otherwise IDLE stays in IDLE.
- DECODE to READ, READ to PROCESS, PROCESS to WRITE and WRITE to IDLE, each unconditionally.

The surrounding core uses the preload ports to seed W, the carry flag and file locations while the unit is idle. It reads any file location through the combinational peek port.

With the default `BANK_W = 3` the data space has 2048 bytes (eight banks of 256).

Top module: `fr_alu_core`

## Requirements
- R1: Instruction bits [15:10] select the operation: 6'b010110 is subtract-with-borrow and 6'b001110 is nibble swap. Bit 9 is the destination bit d, bit 8 is the bank bit a, and bits [7:0] are the file address f.
- R2: Subtract produces f − W − (1 − C) modulo 256. Afterwards C (`flags_o[0]`) is 1 when no borrow occurred, i.e. f ≥ W + (1 − C_in), and 0 otherwise.
- R3: Subtract also sets the other flags in `flags_o`. Bit 1 (DC) is 1 when the low nibbles produce no borrow. Bit 2 (Z) marks a zero result. Bit 4 (N) copies result bit 7. Bit 3 (OV) marks a signed result outside −128..127.
- R4: Swap produces {f[3:0], f[7:4]} and leaves all five flags unchanged.
- R5: With d = 0 the result is written to W and the file location is unchanged. With d = 1 the result is written to the file location and W is unchanged.
- R6: With a = 1 the operand address is {bsr, f}. With a = 0, addresses f < 0x60 map to bank 0 and f ≥ 0x60 map to the highest bank.
- R7: `ready` falls after the accepting edge. `done` is high for exactly one cycle, beginning at the third rising edge after acceptance. Results are visible and `ready` is high again after the following edge.
- R8: Any other value of bits [15:10] runs the same phases but leaves W, the flags and the register file unchanged.
- R9: After reset, `ready` = 1, `done` = 0, W = 0x00 and all flags are 0.
- R10: While busy, a new instruction and the W/carry/file preload requests are ignored. W and the flags change only at the end of the WRITE phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr | input | 16 | Instruction word |
| bsr | input | BANK_W | Bank-select value, sampled with the instruction |
| pre_we | input | 1 | Preload a file location (honoured only when ready) |
| pre_addr | input | 8+BANK_W | Preload address |
| pre_data | input | 8 | Preload data |
| w_we | input | 1 | Preload W (honoured only when ready) |
| w_din | input | 8 | W preload value |
| c_we | input | 1 | Preload carry flag (honoured only when ready) |
| c_din | input | 1 | Carry preload value |
| peek_addr | input | 8+BANK_W | File read address |
| peek_data | output | 8 | File contents at peek_addr |
| ready | output | 1 | Idle and able to accept |
| done | output | 1 | WRITE phase indicator |
| w_o | output | 8 | Working register |
| flags_o | output | 5 | {N, OV, Z, DC, C} |

## Verification
The properties assume that the preload requests and `instr_valid` come from a well-behaved neighbour with no timing constraints beyond the clock. Their stability claims between acceptance and commit rely on preloads being gated by `ready` inside the unit, not on the neighbour keeping quiet. The stimulus deliberately drives a second instruction and a W preload during a busy window, so that the gating is exercised rather than assumed. Otherwise it changes inputs only on falling edges and preloads only while `ready` is high. Operand addresses are always derived with the same bank rule that the requirement states.

// File: rtl/fr_alu_pkg.sv
package fr_alu_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DECODE,
        PH_READ,
        PH_PROCESS,
        PH_WRITE
    } phase_t;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_SUBB,
        OPK_SWAP
    } opk_t;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int OPC_HI   = 15;
    localparam int OPC_LO   = 10;
    localparam int DEST_BIT = 9;
    localparam int BANK_BIT = 8;

    localparam logic [5:0] OPC_SUBB = 6'b010110;
    localparam logic [5:0] OPC_SWAP = 6'b001110;

endpackage

// File: rtl/fr_decode.sv
module fr_decode
    import fr_alu_pkg::*;
#(
    parameter int         BANK_W    = 3,
    parameter logic [7:0] ACC_SPLIT = 8'h60,
    parameter int         ADDR_W    = 8 + BANK_W
) (
    input  logic [15:0]       instr,
    input  logic [BANK_W-1:0] bsr,
    output opk_t              opk,
    output logic              dest_f,
    output logic [ADDR_W-1:0] addr
);

    logic [BYTE_W-1:0] f_field;

    always_comb begin
        f_field = instr[BYTE_W-1:0];
        dest_f  = instr[DEST_BIT];
        unique case (instr[OPC_HI:OPC_LO])
            OPC_SUBB: opk = OPK_SUBB;
            OPC_SWAP: opk = OPK_SWAP;
            default:  opk = OPK_NONE;
        endcase
    end

    always_comb begin
        if (instr[BANK_BIT]) begin
            addr = {bsr, f_field};
        end else if (f_field < ACC_SPLIT) begin
            addr = {{BANK_W{1'b0}}, f_field};
        end else begin
            addr = {{BANK_W{1'b1}}, f_field};
        end
    end

endmodule

// File: rtl/fr_exec.sv
module fr_exec
    import fr_alu_pkg::*;
(
    input  opk_t              opk,
    input  logic [BYTE_W-1:0] op_f,
    input  logic [BYTE_W-1:0] w,
    input  flags_t            flags_in,
    output logic [BYTE_W-1:0] res,
    output flags_t            flags_out
);

    logic              borrow_in;
    logic [BYTE_W:0]   full_diff;
    logic [NIB_W:0]    low_diff;

    always_comb begin
        borrow_in = ~flags_in.c;
        full_diff = {1'b0, op_f} - {1'b0, w} - {{BYTE_W{1'b0}}, borrow_in};
        low_diff  = {1'b0, op_f[NIB_W-1:0]} - {1'b0, w[NIB_W-1:0]}
                  - {{NIB_W{1'b0}}, borrow_in};
    end

    always_comb begin
        res       = op_f;
        flags_out = flags_in;
        unique case (opk)
            OPK_SUBB: begin
                res          = full_diff[BYTE_W-1:0];
                flags_out.c  = ~full_diff[BYTE_W];
                flags_out.dc = ~low_diff[NIB_W];
                flags_out.z  = (full_diff[BYTE_W-1:0] == '0);
                flags_out.n  = full_diff[BYTE_W-1];
                flags_out.ov = (op_f[BYTE_W-1] ^ w[BYTE_W-1])
                             & (full_diff[BYTE_W-1] ^ op_f[BYTE_W-1]);
            end
            OPK_SWAP: begin
                res = {op_f[NIB_W-1:0], op_f[BYTE_W-1:NIB_W]};
            end
            default: begin
                res = op_f;
            end
        endcase
    end

endmodule

// File: rtl/fr_regfile.sv
module fr_regfile
    import fr_alu_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [BYTE_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [BYTE_W-1:0] rdata_b
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/fr_phase_ctl.sv
module fr_phase_ctl
    import fr_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   ready,
    output logic   done
);

    phase_t ph_q, ph_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_nx;
        end
    end

    always_comb begin
        ph_nx = PH_IDLE;
        unique case (ph_q)
            PH_IDLE:    ph_nx = start ? PH_DECODE : PH_IDLE;
            PH_DECODE:  ph_nx = PH_READ;
            PH_READ:    ph_nx = PH_PROCESS;
            PH_PROCESS: ph_nx = PH_WRITE;
            PH_WRITE:   ph_nx = PH_IDLE;
            default:    ph_nx = PH_IDLE;
        endcase
    end

    always_comb begin
        ready = 1'b0;
        done  = 1'b0;
        unique case (ph_q)
            PH_IDLE:  ready = 1'b1;
            PH_WRITE: done  = 1'b1;
            default: begin
                ready = 1'b0;
                done  = 1'b0;
            end
        endcase
    end

    assign phase = ph_q;

endmodule

// File: rtl/fr_alu_core.sv
module fr_alu_core
    import fr_alu_pkg::*;
#(
    parameter int         BANK_W    = 3,
    parameter logic [7:0] ACC_SPLIT = 8'h60,
    parameter int         ADDR_W    = 8 + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [BANK_W-1:0] bsr,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [7:0]        pre_data,
    input  logic              w_we,
    input  logic [7:0]        w_din,
    input  logic              c_we,
    input  logic              c_din,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data,
    output logic              ready,
    output logic              done,
    output logic [7:0]        w_o,
    output logic [4:0]        flags_o
);

    phase_t              phase;
    logic                accept;
    logic [15:0]         instr_q;
    logic [BANK_W-1:0]   bsr_q;

    opk_t                dec_opk;
    logic                dec_dest;
    logic [ADDR_W-1:0]   dec_addr;

    opk_t                opk_q;
    logic                dest_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   op_q;
    logic [BYTE_W-1:0]   res_q;
    flags_t              fl_new_q;

    logic [BYTE_W-1:0]   w_q;
    flags_t              flags_q;

    logic [BYTE_W-1:0]   rf_op_data;
    logic [BYTE_W-1:0]   ex_res;
    flags_t              ex_flags;

    logic                commit_w;
    logic                commit_f;
    logic                commit_fl;
    logic                rf_we;
    logic [ADDR_W-1:0]   rf_waddr;
    logic [BYTE_W-1:0]   rf_wdata;

    fr_phase_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .phase (phase),
        .ready (ready),
        .done  (done)
    );

    fr_decode #(
        .BANK_W    (BANK_W),
        .ACC_SPLIT (ACC_SPLIT),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .instr  (instr_q),
        .bsr    (bsr_q),
        .opk    (dec_opk),
        .dest_f (dec_dest),
        .addr   (dec_addr)
    );

    fr_regfile #(
        .ADDR_W (ADDR_W)
    ) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (addr_q),
        .rdata_a (rf_op_data),
        .raddr_b (peek_addr),
        .rdata_b (peek_data)
    );

    fr_exec u_exec (
        .opk       (opk_q),
        .op_f      (op_q),
        .w         (w_q),
        .flags_in  (flags_q),
        .res       (ex_res),
        .flags_out (ex_flags)
    );

    assign accept = ready & instr_valid;

    // Capture instruction and bank value on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            bsr_q   <= '0;
        end else if (accept) begin
            instr_q <= instr;
            bsr_q   <= bsr;
        end
    end

    // Per-phase pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opk_q    <= OPK_NONE;
            dest_q   <= 1'b0;
            addr_q   <= '0;
            op_q     <= '0;
            res_q    <= '0;
            fl_new_q <= '0;
        end else begin
            unique case (phase)
                PH_DECODE: begin
                    opk_q  <= dec_opk;
                    dest_q <= dec_dest;
                    addr_q <= dec_addr;
                end
                PH_READ: begin
                    op_q <= rf_op_data;
                end
                PH_PROCESS: begin
                    res_q    <= ex_res;
                    fl_new_q <= ex_flags;
                end
                default: begin
                    op_q <= op_q;
                end
            endcase
        end
    end

    always_comb begin
        commit_w  = (phase == PH_WRITE) && (opk_q != OPK_NONE) && !dest_q;
        commit_f  = (phase == PH_WRITE) && (opk_q != OPK_NONE) && dest_q;
        commit_fl = (phase == PH_WRITE) && (opk_q == OPK_SUBB);
        rf_we     = commit_f | (ready & pre_we);
        rf_waddr  = commit_f ? addr_q : pre_addr;
        rf_wdata  = commit_f ? res_q  : pre_data;
    end

    // Architectural W and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q     <= '0;
            flags_q <= '0;
        end else begin
            if (commit_w) begin
                w_q <= res_q;
            end else if (ready && w_we) begin
                w_q <= w_din;
            end
            if (commit_fl) begin
                flags_q <= fl_new_q;
            end else if (ready && c_we) begin
                flags_q.c <= c_din;
            end
        end
    end

    assign w_o     = w_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/fr_alu_chk.sv
module fr_alu_chk
    import fr_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic       ready,
    input logic       done,
    input opk_t       opk,
    input logic       dest_f,
    input logic [7:0] w,
    input logic [4:0] flags
);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && instr_valid) |=> !ready);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R4
    swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && opk == OPK_SWAP) |=> $stable(flags));

    // R8
    none_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && opk == OPK_NONE) |=> ($stable(w) && $stable(flags)));

    // R5
    dest_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dest_f) |=> $stable(w));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done) |=> ($stable(w) && $stable(flags)));

endmodule

bind fr_alu_core fr_alu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .ready       (ready),
    .done        (done),
    .opk         (opk_q),
    .dest_f      (dest_q),
    .w           (w_o),
    .flags       (flags_o)
);

// File: tb/tb_fr_alu_core.sv
`timescale 1ns/1ps
module tb_fr_alu_core;

    localparam int BW = 3;
    localparam int AW = 8 + BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [15:0]   instr = '0;
    logic [BW-1:0] bsr = '0;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [7:0]    pre_data = '0;
    logic          w_we = 1'b0;
    logic [7:0]    w_din = '0;
    logic          c_we = 1'b0;
    logic          c_din = 1'b0;
    logic [AW-1:0] peek_addr = '0;
    logic [7:0]    peek_data;
    logic          ready, done;
    logic [7:0]    w_o;
    logic [4:0]    flags_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [4:0] model_flags = '0;
    logic [7:0] got_w, got_file, exp_w, exp_file;
    logic [4:0] got_flags, exp_flags;
    int         got_lat;
    logic       busy_ready;
    string      kind_tag;

    // {instr, bsr(4), f value, W value, carry(4)}
    localparam int NVEC = 13;
    localparam logic [39:0] VEC [NVEC] = '{
        40'h5A20_0_19_0D_1,
        40'h5821_0_1B_1A_0,
        40'h5A22_0_03_0E_1,
        40'h5B40_5_80_01_1,
        40'h5870_0_7F_FF_1,
        40'h5BFF_7_00_00_0,
        40'h5A10_0_10_01_1,
        40'h3A30_0_53_00_1,
        40'h3965_2_A7_3C_0,
        40'h3A90_0_F0_11_1,
        40'h5E30_0_44_12_1,
        40'h3E31_0_55_66_0,
        40'h0000_1_9A_BC_1
    };

    fr_alu_core dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .bsr(bsr), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .w_we(w_we), .w_din(w_din), .c_we(c_we), .c_din(c_din),
        .peek_addr(peek_addr), .peek_data(peek_data), .ready(ready),
        .done(done), .w_o(w_o), .flags_o(flags_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] eff_addr(input logic [15:0] ins, input logic [BW-1:0] b);
        if (ins[8]) return {b, ins[7:0]};
        if (ins[7:0] < 8'h60) return {{BW{1'b0}}, ins[7:0]};
        return {{BW{1'b1}}, ins[7:0]};
    endfunction

    // Independent reference from the requirements.
    task automatic model(input logic [15:0] ins, input logic [7:0] fv, input logic [7:0] wv);
        int bin, sf, sw, sres;
        logic [7:0] r;
        logic [4:0] fl;
        bin = model_flags[0] ? 0 : 1;
        r   = fv;
        fl  = model_flags;
        if (ins[15:10] == 6'b010110) begin
            kind_tag = "R2/R3 subtract";
            r = 8'(int'(fv) - int'(wv) - bin);
            sf = fv[7] ? int'(fv) - 256 : int'(fv);
            sw = wv[7] ? int'(wv) - 256 : int'(wv);
            sres = sf - sw - bin;
            fl[0] = (int'(fv) >= int'(wv) + bin);
            fl[1] = (int'(fv[3:0]) >= int'(wv[3:0]) + bin);
            fl[2] = (r == 8'h00);
            fl[3] = (sres > 127) || (sres < -128);
            fl[4] = r[7];
        end else if (ins[15:10] == 6'b001110) begin
            kind_tag = "R4 swap";
            r = {fv[3:0], fv[7:4]};
        end else begin
            kind_tag = "R8 unknown";
        end
        exp_flags = fl;
        if (kind_tag == "R8 unknown") begin
            exp_w = wv;
            exp_file = fv;
        end else begin
            exp_w    = ins[9] ? wv : r;
            exp_file = ins[9] ? r : fv;
        end
        model_flags = fl;
    endtask

    task automatic run_instr(input logic [15:0] ins, input logic [BW-1:0] bv,
                             input logic [7:0] fv, input logic [7:0] wv,
                             input logic cin, input logic stray);
        logic [AW-1:0] ea;
        ea = eff_addr(ins, bv);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = ea; pre_data = fv;
        w_we = 1'b1; w_din = wv; c_we = 1'b1; c_din = cin;
        @(negedge clk);
        pre_we = 1'b0; w_we = 1'b0; c_we = 1'b0;
        model_flags[0] = cin;
        instr = ins; bsr = bv; instr_valid = 1'b1; peek_addr = ea;
        @(negedge clk);
        instr_valid = 1'b0;
        busy_ready = ready;
        if (stray) begin
            instr_valid = 1'b1; instr = 16'h3800;
            w_we = 1'b1; w_din = 8'hAA; c_we = 1'b1; c_din = ~cin;
        end
        got_lat = 0;
        while (!done && got_lat < 20) begin
            @(negedge clk);
            got_lat++;
        end
        instr_valid = 1'b0; w_we = 1'b0; c_we = 1'b0;
        @(negedge clk);
        got_w = w_o; got_flags = flags_o; got_file = peek_data;
        model(ins, fv, wv);
    endtask

    task automatic run_check(input logic [15:0] ins, input logic [BW-1:0] bv,
                             input logic [7:0] fv, input logic [7:0] wv, input logic cin);
        run_instr(ins, bv, fv, wv, cin, 1'b0);
        chk({"R1/R5 W after ", kind_tag}, {8'h0, got_w}, {8'h0, exp_w});
        chk({"flags after ", kind_tag}, {11'h0, got_flags}, {11'h0, exp_flags});
        chk({"R5/R6 file after ", kind_tag}, {8'h0, got_file}, {8'h0, exp_file});
        chk("R7 latency to done", 16'(got_lat), 16'd3);
        chk("R7 ready low while busy", {15'h0, busy_ready}, 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 ready after reset", {15'h0, ready}, 16'h1);
        chk("R9 done after reset", {15'h0, done}, 16'h0);
        chk("R9 W after reset", {8'h0, w_o}, 16'h0);
        chk("R9 flags after reset", {11'h0, flags_o}, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            run_check(VEC[i][39:24], VEC[i][22:20], VEC[i][19:12], VEC[i][11:4], VEC[i][0]);
        end

        // R2 literal cases
        run_instr(16'h5A22, 3'd0, 8'h03, 8'h0E, 1'b1, 1'b0);
        chk("R2 literal 03-0E result", {8'h0, got_file}, 16'h00F5);
        chk("R2 literal 03-0E flags", {11'h0, got_flags}, 16'h0010);
        run_instr(16'h5821, 3'd0, 8'h1B, 8'h1A, 1'b0, 1'b0);
        chk("R2 literal 1B-1A result", {8'h0, got_w}, 16'h0000);
        chk("R2 literal 1B-1A flags", {11'h0, got_flags}, 16'h0007);
        run_instr(16'h5A20, 3'd0, 8'h19, 8'h0D, 1'b1, 1'b0);
        chk("R2 literal 19-0D result", {8'h0, got_file}, 16'h000C);
        chk("R3 literal 19-0D flags", {11'h0, got_flags}, 16'h0001);

        // R4 swap after flags were set by a subtract
        run_instr(16'h5821, 3'd0, 8'h03, 8'h0E, 1'b1, 1'b0);
        run_instr(16'h3A44, 3'd0, 8'h53, 8'h00, 1'b1, 1'b0);
        chk("R4 swap 53 result", {8'h0, got_file}, 16'h0035);
        chk("R4 swap keeps flags", {11'h0, got_flags}, 16'h0011);

        // R6 access-high address does not touch bank 0
        @(negedge clk);
        pre_we = 1'b1; pre_addr = 11'h070; pre_data = 8'h11;
        @(negedge clk);
        pre_we = 1'b0;
        run_instr(16'h5A70, 3'd2, 8'h20, 8'h01, 1'b1, 1'b0);
        chk("R6 high access result in top bank", {8'h0, got_file}, 16'h001F);
        peek_addr = 11'h070;
        @(negedge clk);
        chk("R6 bank 0 alias untouched", {8'h0, peek_data}, 16'h0011);

        // R10 stray instruction and preloads while busy
        run_instr(16'h5A50, 3'd0, 8'h40, 8'h10, 1'b1, 1'b1);
        chk("R10 W not preloaded while busy", {8'h0, got_w}, 16'h0010);
        chk("R10 file result of first instruction", {8'h0, got_file}, {8'h0, exp_file});
        chk("R10 flags from first instruction only", {11'h0, got_flags}, {11'h0, exp_flags});
        chk("R10 stray not accepted", {15'h0, ready}, 16'h1);
        @(negedge clk);
        chk("R10 still idle after stray", {15'h0, ready}, 16'h1);
        chk("R10 W unchanged by stray", {8'h0, w_o}, 16'h0010);

        // Random operands against the reference
        for (int k = 0; k < 40; k++) begin
            logic [5:0]  opc;
            logic [31:0] rv;
            rv = $urandom;
            unique case (rv[1:0])
                2'd0, 2'd1: opc = 6'b010110;
                2'd2:       opc = 6'b001110;
                default:    opc = rv[7:2];
            endcase
            run_check({opc, rv[9:8], rv[17:10]}, rv[20:18], rv[28:21], 8'($urandom), rv[31]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule